// File: doc/BRIEF.md
# Serial Peripheral Master with Slave Ready Gating

This block drives a four-wire synchronous serial bus in mode 0 and adds a fifth, slave-driven, active-low ready line. A requester hands over one command word and a count of response bytes in a single valid/ready handshake. The master lowers chip select, waits a programmable lead gap, shifts the command out MSB first, waits a programmable turnaround gap, and then clocks in the response one byte at a time. Before every response byte it waits for the slave to pull ready low. After the last clock it holds chip select low for a programmable trail gap and then releases it.

When ready gating is switched off, a fixed programmable delay takes the place of every ready wait. When gating is on and ready stays high beyond a programmable limit, the transaction is abandoned: no further bytes are clocked, the trail gap still runs, and the completion pulse carries an error flag. The serial clock is derived from the system clock by a programmable half-period divider. Received bytes leave the block with a one-cycle valid strobe.

Top module: `spi_rdy_master`

## Requirements
- R1: Out of reset and whenever no transaction runs, cs_no is 1, sclk_o is 0, mosi_o is 0, req_ready_o is 1 and rx_valid_o, done_o, err_o are 0; req_ready_o is 1 only while cs_no is 1.
- R2: A request accepted on a clock edge (req_valid_i and req_ready_o both 1) drives cs_no to 0 in the next cycle; sclk_o then stays 0 for lead_gap_i+1 cycles before the first clock pulse.
- R3: Each bit is one serial clock period: sclk_o is 0 for clk_div_i+1 system cycles and then 1 for clk_div_i+1 cycles; sclk_o is never 1 while cs_no is 1.
- R4: The command is CMD_W bits (a multiple of 8), sent on mosi_o MSB first; each bit is presented from the start of its low half and held through its high half, so mosi_o changes only when sclk_o falls; mosi_o is 0 outside command bits.
- R5: miso_i is sampled when sclk_o rises, MSB first; each response byte appears on rx_data_o with rx_valid_o high for exactly the one cycle after that byte's final falling clock.
- R6: When resp_len_i is not 0, sclk_o stays 0 for turn_gap_i+1 cycles after the command's final falling clock, before the first ready wait.
- R7: With rdy_en_i at 1, each response byte starts clocking in the cycle after the master observes rdy_ni low through a two-stage synchronizer; while the observed level is high, sclk_o stays 0.
- R8: The ready check is repeated before every response byte, not only after the command.
- R9: With rdy_en_i at 0, rdy_ni has no effect and each ready wait lasts exactly fix_dly_i+1 cycles.
- R10: With rdy_en_i at 1, if the observed ready stays high for tmo_lim_i+1 wait cycles, the remaining bytes are not clocked, the trail gap runs, and err_o pulses together with done_o.
- R11: After the last clock (or an abort), cs_no stays 0 with sclk_o at 0 for trail_gap_i+1 cycles; then cs_no returns to 1 and done_o pulses for one cycle in that same cycle.
- R12: With resp_len_i equal to 0, no turnaround gap and no ready wait occur: the trail gap follows the command directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Master idle and able to take a request |
| cmd_i | input | CMD_W | Command word to send |
| resp_len_i | input | LEN_W | Number of response bytes |
| clk_div_i | input | DIV_W | Serial clock half period minus one, in system cycles |
| lead_gap_i | input | CNT_W | Idle cycles minus one between chip select low and first clock |
| turn_gap_i | input | CNT_W | Idle cycles minus one between command and first ready wait |
| trail_gap_i | input | CNT_W | Idle cycles minus one between last clock and chip select high |
| rdy_en_i | input | 1 | 1: gate response bytes on rdy_ni; 0: use fixed delay |
| fix_dly_i | input | CNT_W | Fixed wait length minus one when gating is off |
| tmo_lim_i | input | CNT_W | Ready wait limit minus one before abort |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to slave |
| cs_no | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data from slave |
| rdy_ni | input | 1 | Slave ready, active low, asynchronous |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| done_o | output | 1 | One-cycle strobe at chip select release |
| err_o | output | 1 | Abort flag, valid with done_o |

## Verification
The bench runs transactions whose command and response patterns alternate bit values so a shifted, reversed or stuck lane shows up at once, and it varies the divider between one and three cycles per half period to separate an off-by-one in the half-period count from a wrong edge. Ready is held low throughout in one case, released late and re-raised between bytes in another, which distinguishes a master that checks ready only once from one that checks it per byte. A fixed-delay case holds ready high to show that it is ignored, and two timeout cases, one before the first byte and one before a later byte, tell a clean abort after partial data from one that never starts. A zero-length response confirms that the turnaround and wait are skipped.

// File: rtl/spi_rdy_pkg.sv
`timescale 1ns/1ps
package spi_rdy_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CMD,
    ST_TURN,
    ST_WAIT,
    ST_RESP,
    ST_TRAIL
  } xfer_st_e;
endpackage

// File: rtl/spi_rdy_sync.sv
`timescale 1ns/1ps
module spi_rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_ni,
  output logic rdy_no
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= rdy_ni;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], rdy_ni};
      end
    end
  endgenerate

  assign rdy_no = sync_q[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
`timescale 1ns/1ps
module spi_bit_engine
  import spi_rdy_pkg::*;
#(
  parameter int unsigned SH_W  = 16,
  parameter int unsigned DIV_W = 8,
  localparam int unsigned NB_W = $clog2(SH_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SH_W-1:0]   data_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              drive_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o
);
  logic             active_q, sclk_q, mosi_q, drive_q;
  logic [DIV_W-1:0] hc_q;
  logic [NB_W-1:0]  left_q;
  logic [SH_W-1:0]  sh_q;
  logic             edge_now;

  assign edge_now = active_q && (hc_q == half_i);
  assign done_o   = edge_now && sclk_q && (left_q == NB_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      drive_q  <= 1'b0;
      hc_q     <= '0;
      left_q   <= '0;
      sh_q     <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      sclk_q   <= 1'b0;
      hc_q     <= '0;
      sh_q     <= data_i;
      drive_q  <= drive_i;
      mosi_q   <= drive_i & data_i[SH_W-1];
      left_q   <= nbits_i;
    end else if (active_q) begin
      if (edge_now) begin
        hc_q <= '0;
        if (!sclk_q) begin
          // rising edge: capture slave data
          sclk_q <= 1'b1;
          sh_q   <= {sh_q[SH_W-2:0], miso_i};
        end else begin
          // falling edge: advance outgoing bit
          sclk_q <= 1'b0;
          if (left_q == NB_W'(1)) begin
            active_q <= 1'b0;
            mosi_q   <= 1'b0;
          end else begin
            left_q <= left_q - NB_W'(1);
            mosi_q <= drive_q & sh_q[SH_W-1];
          end
        end
      end else begin
        hc_q <= hc_q + DIV_W'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign rx_o   = sh_q[BYTE_W-1:0];
endmodule

// File: rtl/spi_rdy_master.sv
`timescale 1ns/1ps
module spi_rdy_master
  import spi_rdy_pkg::*;
#(
  parameter int unsigned CMD_W       = 16,
  parameter int unsigned LEN_W       = 4,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [LEN_W-1:0]  resp_len_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [CNT_W-1:0]  lead_gap_i,
  input  logic [CNT_W-1:0]  turn_gap_i,
  input  logic [CNT_W-1:0]  trail_gap_i,
  input  logic              rdy_en_i,
  input  logic [CNT_W-1:0]  fix_dly_i,
  input  logic [CNT_W-1:0]  tmo_lim_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  input  logic              miso_i,
  input  logic              rdy_ni,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned NB_W = $clog2(CMD_W + 1);

  xfer_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [LEN_W-1:0]  left_q;
  logic              abort_q;
  logic [BYTE_W-1:0] rx_q;
  logic              rxv_q, done_q, err_q;

  logic              rdy_s;
  logic              lead_end, wait_go, wait_tmo;
  logic              eng_start, eng_done, eng_drive;
  logic [CMD_W-1:0]  eng_data;
  logic [NB_W-1:0]   eng_nbits;
  logic [BYTE_W-1:0] eng_rx;

  spi_rdy_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rdy_ni (rdy_ni),
    .rdy_no (rdy_s)
  );

  assign lead_end  = (st_q == ST_LEAD) && (cnt_q == lead_gap_i);
  assign wait_go   = (st_q == ST_WAIT) && (rdy_en_i ? !rdy_s : (cnt_q == fix_dly_i));
  assign wait_tmo  = (st_q == ST_WAIT) && rdy_en_i && rdy_s && (cnt_q == tmo_lim_i);
  assign eng_start = lead_end || wait_go;
  assign eng_drive = (st_q == ST_LEAD);
  assign eng_data  = eng_drive ? cmd_q : '0;
  assign eng_nbits = eng_drive ? NB_W'(CMD_W) : NB_W'(BYTE_W);

  spi_bit_engine #(.SH_W(CMD_W), .DIV_W(DIV_W)) i_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .data_i  (eng_data),
    .nbits_i (eng_nbits),
    .drive_i (eng_drive),
    .half_i  (clk_div_i),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .done_o  (eng_done),
    .rx_o    (eng_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      left_q  <= '0;
      abort_q <= 1'b0;
      rx_q    <= '0;
      rxv_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rxv_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          st_q    <= ST_LEAD;
          cnt_q   <= '0;
          cmd_q   <= cmd_i;
          left_q  <= resp_len_i;
          abort_q <= 1'b0;
        end
        ST_LEAD: begin
          if (lead_end) begin
            st_q  <= ST_CMD;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_CMD: if (eng_done) begin
          cnt_q <= '0;
          st_q  <= (left_q == '0) ? ST_TRAIL : ST_TURN;
        end
        ST_TURN: begin
          if (cnt_q == turn_gap_i) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_WAIT: begin
          if (wait_go) begin
            st_q  <= ST_RESP;
            cnt_q <= '0;
          end else if (wait_tmo) begin
            st_q    <= ST_TRAIL;
            cnt_q   <= '0;
            abort_q <= 1'b1;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_RESP: if (eng_done) begin
          rxv_q  <= 1'b1;
          rx_q   <= eng_rx;
          left_q <= left_q - LEN_W'(1);
          cnt_q  <= '0;
          st_q   <= (left_q == LEN_W'(1)) ? ST_TRAIL : ST_WAIT;
        end
        ST_TRAIL: begin
          if (cnt_q == trail_gap_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            err_q  <= abort_q;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign cs_no       = (st_q == ST_IDLE);
  assign rx_data_o   = rx_q;
  assign rx_valid_o  = rxv_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/spi_rdy_master_chk.sv
`timescale 1ns/1ps
module spi_rdy_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_no,
  input logic rx_valid_o,
  input logic done_o,
  input logic err_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cs_no && !sclk_o));

  assert_clock_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);

  assert_mosi_hold_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  assert_mosi_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !mosi_o);

  assert_rx_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (!sclk_o && !cs_no));

  assert_rx_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_err_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  assert_release_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o);

  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind spi_rdy_master spi_rdy_master_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .cs_no       (cs_no),
  .rx_valid_o  (rx_valid_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_spi_rdy_master.sv
`timescale 1ns/1ps
module test_spi_rdy_master;
  localparam int CMD_W = 16;
  localparam int LEN_W = 4;
  localparam int DIV_W = 8;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             req_valid_i;
  logic             req_ready_o;
  logic [CMD_W-1:0] cmd_i;
  logic [LEN_W-1:0] resp_len_i;
  logic [DIV_W-1:0] clk_div_i;
  logic [CNT_W-1:0] lead_gap_i, turn_gap_i, trail_gap_i, fix_dly_i, tmo_lim_i;
  logic             rdy_en_i;
  logic             sclk_o, mosi_o, cs_no, miso_i, rdy_ni;
  logic [7:0]       rx_data_o;
  logic             rx_valid_o, done_o, err_o;

  always #2.5 clk = ~clk;

  spi_rdy_master i_spi_rdy_master (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .cmd_i(cmd_i), .resp_len_i(resp_len_i), .clk_div_i(clk_div_i),
    .lead_gap_i(lead_gap_i), .turn_gap_i(turn_gap_i), .trail_gap_i(trail_gap_i),
    .rdy_en_i(rdy_en_i), .fix_dly_i(fix_dly_i), .tmo_lim_i(tmo_lim_i),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_no(cs_no), .miso_i(miso_i), .rdy_ni(rdy_ni),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .done_o(done_o), .err_o(err_o)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  int   n_cyc = 0;
  logic e_cs, e_sclk, e_mosi, e_done, e_err, e_rdy;
  logic pend;
  logic [7:0] pend_b;
  logic h1, h2;
  logic [7:0] g_resp [4];
  int   g_hold [4];

  // one cycle of the reference model: compare everything seen after the last edge
  task automatic step(input string tag);
    logic ok;
    @(negedge clk);
    n_cyc++;
    h2 = h1;
    h1 = rdy_ni;
    n_chk++;
    ok = (cs_no === e_cs) && (sclk_o === e_sclk) && (mosi_o === e_mosi) &&
         (rx_valid_o === pend) && (done_o === e_done) && (err_o === e_err) &&
         (req_ready_o === e_rdy) && (!pend || rx_data_o === pend_b);
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: cs,sclk,mosi,rxv,rx,done,err,rdy got %b%b%b%b %h %b%b%b expected %b%b%b%b %h %b%b%b",
               tag, n_cyc, cs_no, sclk_o, mosi_o, rx_valid_o, rx_data_o, done_o, err_o, req_ready_o,
               e_cs, e_sclk, e_mosi, pend, pend_b, e_done, e_err, e_rdy);
    end
    pend = 1'b0;
  endtask

  task automatic xfer(input logic [CMD_W-1:0] cmd, input int len);
    int  d;
    int  w;
    logic aborted;
    logic go;
    d = int'(clk_div_i) + 1;
    aborted = 1'b0;
    rdy_ni = (g_hold[0] > 0);
    req_valid_i = 1'b1;
    cmd_i = cmd;
    resp_len_i = LEN_W'(len);
    e_cs = 1'b0; e_sclk = 1'b0; e_mosi = 1'b0; e_done = 1'b0; e_err = 1'b0; e_rdy = 1'b0;
    for (int i = 0; i <= int'(lead_gap_i); i++) begin
      step("R2 lead gap");
      req_valid_i = 1'b0;
    end
    for (int b = 0; b < CMD_W; b++) begin
      miso_i = b[0];
      for (int h = 0; h < 2; h++) begin
        for (int c = 0; c < d; c++) begin
          e_sclk = h[0];
          e_mosi = cmd[CMD_W-1-b];
          step("R3 R4 command bit");
        end
      end
    end
    e_sclk = 1'b0;
    e_mosi = 1'b0;
    if (len > 0) begin
      for (int i = 0; i <= int'(turn_gap_i); i++) step("R6 turnaround");
      for (int k = 0; k < len; k++) begin
        w = 0;
        go = 1'b0;
        while (!go && !aborted) begin
          step("R5 R7 R8 R9 R10 ready wait");
          if (rdy_en_i ? (h2 == 1'b0) : (w == int'(fix_dly_i))) go = 1'b1;
          else if (rdy_en_i && w == int'(tmo_lim_i)) aborted = 1'b1;
          else w++;
          rdy_ni = ((w + 1) < g_hold[k]);
        end
        if (aborted) break;
        rdy_ni = (k + 1 < len) && (g_hold[(k + 1) % 4] > 0);
        for (int b = 0; b < 8; b++) begin
          miso_i = g_resp[k][7-b];
          for (int h = 0; h < 2; h++) begin
            for (int c = 0; c < d; c++) begin
              e_sclk = h[0];
              step("R3 R5 response bit");
            end
          end
        end
        e_sclk = 1'b0;
        pend = 1'b1;
        pend_b = g_resp[k];
      end
    end
    for (int i = 0; i <= int'(trail_gap_i); i++) step("R5 R11 R12 trail gap");
    e_cs = 1'b1; e_rdy = 1'b1; e_done = 1'b1; e_err = aborted;
    step("R10 R11 release");
    e_done = 1'b0; e_err = 1'b0;
    step("R1 idle after transfer");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req_valid_i = 1'b0; cmd_i = '0; resp_len_i = '0;
    clk_div_i = '0; lead_gap_i = '0; turn_gap_i = '0; trail_gap_i = '0;
    rdy_en_i = 1'b1; fix_dly_i = '0; tmo_lim_i = 12'd50; miso_i = 1'b0; rdy_ni = 1'b1;
    h1 = 1'b1; h2 = 1'b1; pend = 1'b0; pend_b = '0;
    for (int i = 0; i < 4; i++) begin g_resp[i] = '0; g_hold[i] = 0; end
    e_cs = 1'b1; e_sclk = 1'b0; e_mosi = 1'b0; e_done = 1'b0; e_err = 1'b0; e_rdy = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step("R1 reset state");
    step("R1 reset state");

    // ready already low: lead/turn/trail gaps, fastest clock
    clk_div_i = 8'd0; lead_gap_i = 12'd2; turn_gap_i = 12'd1; trail_gap_i = 12'd3;
    g_resp[0] = 8'h96; g_resp[1] = 8'h3B; g_hold[0] = 0; g_hold[1] = 0;
    xfer(16'hA53C, 2);

    // late ready, re-raised between bytes, slower clock, minimal gaps
    clk_div_i = 8'd2; lead_gap_i = 12'd0; turn_gap_i = 12'd0; trail_gap_i = 12'd0;
    g_resp[0] = 8'hC3; g_resp[1] = 8'h5A; g_resp[2] = 8'h01;
    g_hold[0] = 5; g_hold[1] = 3; g_hold[2] = 0;
    xfer(16'h81FE, 3);

    // gating off: ready held high must not matter
    rdy_en_i = 1'b0; fix_dly_i = 12'd4; clk_div_i = 8'd1;
    lead_gap_i = 12'd1; turn_gap_i = 12'd2; trail_gap_i = 12'd1;
    g_resp[0] = 8'hE7; g_hold[0] = 1000;
    xfer(16'h7F80, 1);

    // timeout before the first byte
    rdy_en_i = 1'b1; tmo_lim_i = 12'd6; clk_div_i = 8'd0;
    g_resp[0] = 8'hAA; g_resp[1] = 8'h55; g_hold[0] = 1000; g_hold[1] = 1000;
    xfer(16'h1234, 2);

    // no response bytes: trail follows command
    lead_gap_i = 12'd1; trail_gap_i = 12'd2; g_hold[0] = 0;
    xfer(16'h0F0F, 0);

    // timeout before a later byte after one good byte
    tmo_lim_i = 12'd4; turn_gap_i = 12'd0;
    g_resp[0] = 8'h69; g_resp[1] = 8'hFF; g_resp[2] = 8'h00;
    g_hold[0] = 0; g_hold[1] = 1000; g_hold[2] = 0;
    xfer(16'hC001, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule